// File: doc/BRIEF.md
# Memory Performance Counter Bank

This block gathers activity statistics for a memory controller. It holds one cycle counter and a set of general event counters. Each counter has its own control word. The control word picks an event code, turns counting on, clears the count and shows an overflow flag. Each clock the controller presents a vector of single-cycle event strobes, indexed by event code. Each event counter adds one on any clock where the strobe for its chosen code is high. Typical codes are 0x04 for read accesses, 0x05 for write accesses, 0x20 and 0x21 for read and write commands, and 0x37 for refresh.

The cycle counter governs the whole bank. All counters run only while it is enabled and has not overflowed. When it wraps, every counter freezes and the single interrupt line rises. Software then reads the counts and restarts the bank. The cycle counter can be preloaded so that it wraps early, which bounds the time between samples. A plain 32-bit register port gives access to the control words and the counts. A write takes effect at the clock edge, and a read is combinational from the address.

Top module: `memperf_counter_bank`

## Requirements
- R1: After reset all counts read 0, the interrupt is low, and every control word reads 0 except on the event counters (index 1 and up), where the clear bit (bit 1) reads 1.
- R2: Control word n is at byte offset 4*n with overflow at bit 0 (read-only, writes to it are ignored), clear at bit 1, enable at bit 2, preload byte at bits [23:16] and event code at bits [31:24]; count n reads at byte offset 0x20 + 4*n, zero-extended to 32 bits.
- R3: Counter 0 adds one on every clock while the bank is running; its event-code field always reads 0 and writes to it are ignored.
- R4: An event counter adds one on a clock where the bank is running, its enable bit is set and strobe[code] is high; a code at or above the number of strobe inputs never counts.
- R5: The bank runs only while counter 0 is enabled and its overflow flag is clear; clearing counter 0's enable freezes every count.
- R6: When counter 0 passes its all-ones value it wraps to 0, sets its overflow flag and freezes every counter; the interrupt equals that flag and stays high until counter 0 is cleared.
- R7: By default an event counter that passes all-ones keeps the all-ones value, sets its overflow flag and stops counting until cleared; the interrupt does not rise for it.
- R8: With the wrap option set, an event counter that passes all-ones wraps to 0, sets its overflow flag and keeps counting.
- R9: Counter 0 clears (count and overflow flag to 0) only on a write with clear = 1 while its stored clear bit is 0; the stored clear bit reads back the last value written.
- R10: Writing clear = 0 to an event counter zeroes its count and overflow flag; its clear bit reads 0 for one cycle, then returns to 1 without any write.
- R11: A write that sets counter 0's enable while it is disabled and carries a nonzero preload byte places that byte in count bits [PRE_LSB+7:PRE_LSB] (bits [23:16] by default). The other count bits are zeroed if the same write clears, and are kept otherwise.
- R12: Reads from any offset other than the control and count words, including unaligned ones, return 0; writes to them, and to the count words, change nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| reg_wr | input | 1 | Write strobe for the register port |
| reg_addr | input | ADDR_W | Byte offset for read and write |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr (combinational) |
| evt_strobe | input | NUM_EVT | One strobe per event code, high for each clock the event occurs |
| irq | output | 1 | Cycle counter overflow interrupt |

## Verification
A write or strobe that is present at a rising edge shows up in the counts and flags right after that same edge. The read data follows the address with no delay, and the interrupt is a register bit, so both are due within the cycle that follows the stimulus. The one later effect is the event counter's clear bit: it returns to 1 a second edge after the write. The bench changes inputs just after a falling edge and steps its model at the next rising edge. It then compares the read data for the driven address, and the interrupt, at the following falling edge, so the values it sees already include every register the stimulus touched. Narrow counters with an early preload make both kinds of overflow reachable in a few thousand cycles.

// File: rtl/memperf_pkg.sv
// Shared definitions for the memory performance counter bank.
// Assumes a 32-bit register port with word-aligned accesses.
package memperf_pkg;

    localparam int REG_W      = 32;
    localparam int CODE_W     = 8;
    localparam int PRE_W      = 8;
    localparam int CTRL_WORD0 = 0;   // word index of control word 0
    localparam int CNT_WORD0  = 8;   // word index of count 0 (byte 0x20)

    // Control word layout, MSB first, matching the register map
    typedef struct packed {
        logic [CODE_W-1:0] evsel;
        logic [PRE_W-1:0]  preload;
        logic [12:0]       rsvd;
        logic              en;
        logic              clr;
        logic              ovf;
    } ctrl_t;

endpackage

// File: rtl/memperf_counter.sv
// One counter with its control word.
// IS_CYCLE selects the cycle-counter variant: it counts every running clock,
// clears on a 0->1 clear handshake, accepts a preload and always wraps.
// Event variant: counts on its selected strobe, clears on clear = 0 and
// restores the clear bit by itself; on overflow it holds unless LEGACY_WRAP.
// Assumes CNT_W >= PRE_LSB + 8.
module memperf_counter
    import memperf_pkg::*;
#(
    parameter int CNT_W       = 32,
    parameter int PRE_LSB     = 16,
    parameter bit IS_CYCLE    = 1'b0,
    parameter bit LEGACY_WRAP = 1'b0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_sel,
    input  logic [REG_W-1:0] wdata,
    input  logic             run_all,
    input  logic             evt_hit,
    output logic [REG_W-1:0] ctl_word,
    output logic [CNT_W-1:0] cnt
);

    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    ctrl_t             wr_f;
    logic              en_q, clr_q, ovf_q;
    logic [PRE_W-1:0]  pre_q;
    logic [CODE_W-1:0] sel_q;
    logic [CNT_W-1:0]  cnt_q, cnt_d;
    logic              ovf_d;
    logic              clear_fire, preload_fire, inc_req, at_max;
    logic              unused_bits;

    assign wr_f        = ctrl_t'(wdata);
    assign unused_bits = ^{wr_f.rsvd, wr_f.ovf, wr_f.evsel, evt_hit};

    // Decide clear, preload and increment for this clock
    always_comb begin
        at_max = &cnt_q;
        if (IS_CYCLE) begin
            clear_fire = wr_sel && !clr_q && wr_f.clr;
            inc_req    = run_all;
        end else begin
            clear_fire = wr_sel && !wr_f.clr;
            inc_req    = run_all && en_q && evt_hit && (LEGACY_WRAP || !ovf_q);
        end
        preload_fire = IS_CYCLE && wr_sel && !en_q && wr_f.en && (wr_f.preload != '0);
    end

    // Next count and overflow flag; a write outranks an increment
    always_comb begin
        cnt_d = cnt_q;
        ovf_d = ovf_q;
        if (clear_fire || preload_fire) begin
            if (clear_fire) begin
                cnt_d = '0;
                ovf_d = 1'b0;
            end
            if (preload_fire) begin
                cnt_d[PRE_LSB +: PRE_W] = wr_f.preload;
            end
        end else if (inc_req) begin
            if (at_max) begin
                ovf_d = 1'b1;
                cnt_d = (IS_CYCLE || LEGACY_WRAP) ? '0 : cnt_q;
            end else begin
                cnt_d = cnt_q + ONE;
            end
        end
    end

    // Register the count, flag and control fields
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q  <= 1'b0;
            clr_q <= !IS_CYCLE;
            ovf_q <= 1'b0;
            pre_q <= '0;
            sel_q <= '0;
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
            ovf_q <= ovf_d;
            if (wr_sel) begin
                en_q  <= wr_f.en;
                clr_q <= wr_f.clr;
                pre_q <= wr_f.preload;
                if (!IS_CYCLE) begin
                    sel_q <= wr_f.evsel;
                end
            end else if (!IS_CYCLE) begin
                clr_q <= 1'b1;
            end
        end
    end

    // Assemble the readable control word
    always_comb begin
        ctrl_t w;
        w         = '0;
        w.evsel   = sel_q;
        w.preload = pre_q;
        w.en      = en_q;
        w.clr     = clr_q;
        w.ovf     = ovf_q;
        ctl_word  = w;
    end

    assign cnt = cnt_q;

endmodule

// File: rtl/memperf_evt_mux.sv
// Selects, for each counter, the strobe named by its event code.
// Codes at or above NUM_EVT select nothing. Pure combinational.
module memperf_evt_mux
    import memperf_pkg::*;
#(
    parameter int NUM_CTR = 4,
    parameter int NUM_EVT = 64
) (
    input  logic [NUM_CTR*CODE_W-1:0] sel_flat,
    input  logic [NUM_EVT-1:0]        strobe,
    output logic [NUM_CTR-1:0]        hit
);

    for (genvar k = 0; k < NUM_CTR; k++) begin : g_sel
        // Pick the strobe whose index equals this counter's code
        always_comb begin
            hit[k] = 1'b0;
            for (int e = 0; e < NUM_EVT; e++) begin
                if (sel_flat[k*CODE_W +: CODE_W] == CODE_W'(e)) begin
                    hit[k] = strobe[e];
                end
            end
        end
    end

endmodule

// File: rtl/memperf_reg_if.sv
// Address decode for the register port: per-counter write selects and the
// combinational read mux. Unaligned or unmapped offsets read 0 and are
// never selected for write; count words are read-only.
module memperf_reg_if
    import memperf_pkg::*;
#(
    parameter int NUM_CTR = 4,
    parameter int CNT_W   = 32,
    parameter int ADDR_W  = 8
) (
    input  logic                     reg_wr,
    input  logic [ADDR_W-1:0]        reg_addr,
    input  logic [NUM_CTR*REG_W-1:0] ctl_flat,
    input  logic [NUM_CTR*CNT_W-1:0] cnt_flat,
    output logic [NUM_CTR-1:0]       wr_sel,
    output logic [REG_W-1:0]         reg_rdata
);

    localparam int WORD_W = ADDR_W - 2;

    logic              aligned;
    logic [WORD_W-1:0] word;

    assign aligned = (reg_addr[1:0] == 2'b00);
    assign word    = reg_addr[ADDR_W-1:2];

    // Write selects go only to control words
    always_comb begin
        for (int k = 0; k < NUM_CTR; k++) begin
            wr_sel[k] = reg_wr && aligned && (word == WORD_W'(CTRL_WORD0 + k));
        end
    end

    // Read mux over control words and counts
    always_comb begin
        reg_rdata = '0;
        for (int k = 0; k < NUM_CTR; k++) begin
            if (aligned && word == WORD_W'(CTRL_WORD0 + k)) begin
                reg_rdata = ctl_flat[k*REG_W +: REG_W];
            end
            if (aligned && word == WORD_W'(CNT_WORD0 + k)) begin
                reg_rdata            = '0;
                reg_rdata[CNT_W-1:0] = cnt_flat[k*CNT_W +: CNT_W];
            end
        end
    end

endmodule

// File: rtl/memperf_counter_bank.sv
// Performance counter bank for a memory controller: counter 0 counts cycles
// and gates the bank, the others count selected event strobes.
// Assumes evt_strobe is synchronous to clk and NUM_CTR + 8 fits the
// ADDR_W-2 word index.
module memperf_counter_bank
    import memperf_pkg::*;
#(
    parameter int NUM_CTR     = 4,
    parameter int CNT_W       = 32,
    parameter int PRE_LSB     = 16,
    parameter int NUM_EVT     = 64,
    parameter int ADDR_W      = 8,
    parameter bit LEGACY_WRAP = 1'b0
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               reg_wr,
    input  logic [ADDR_W-1:0]  reg_addr,
    input  logic [31:0]        reg_wdata,
    output logic [31:0]        reg_rdata,
    input  logic [NUM_EVT-1:0] evt_strobe,
    output logic               irq
);

    logic [NUM_CTR-1:0]        wr_sel;
    logic [NUM_CTR*REG_W-1:0]  ctl_flat;
    logic [NUM_CTR*CNT_W-1:0]  cnt_flat;
    logic [NUM_CTR*CODE_W-1:0] sel_flat;
    logic [NUM_CTR-1:0]        ovf_vec;
    logic [NUM_CTR-1:0]        evt_hit;
    logic                      run_all;

    memperf_reg_if #(
        .NUM_CTR(NUM_CTR),
        .CNT_W  (CNT_W),
        .ADDR_W (ADDR_W)
    ) u_regs (
        .reg_wr   (reg_wr),
        .reg_addr (reg_addr),
        .ctl_flat (ctl_flat),
        .cnt_flat (cnt_flat),
        .wr_sel   (wr_sel),
        .reg_rdata(reg_rdata)
    );

    memperf_evt_mux #(
        .NUM_CTR(NUM_CTR),
        .NUM_EVT(NUM_EVT)
    ) u_evt (
        .sel_flat(sel_flat),
        .strobe  (evt_strobe),
        .hit     (evt_hit)
    );

    for (genvar k = 0; k < NUM_CTR; k++) begin : g_ctr
        memperf_counter #(
            .CNT_W      (CNT_W),
            .PRE_LSB    (PRE_LSB),
            .IS_CYCLE   (k == 0),
            .LEGACY_WRAP(LEGACY_WRAP)
        ) u_ctr (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_sel  (wr_sel[k]),
            .wdata   (reg_wdata),
            .run_all (run_all),
            .evt_hit (evt_hit[k]),
            .ctl_word(ctl_flat[k*REG_W +: REG_W]),
            .cnt     (cnt_flat[k*CNT_W +: CNT_W])
        );
        assign ovf_vec[k]                 = ctl_flat[k*REG_W];
        assign sel_flat[k*CODE_W +: CODE_W] = ctl_flat[k*REG_W + 24 +: CODE_W];
    end

    // The bank runs while the cycle counter is enabled and not overflowed
    assign run_all = ctl_flat[2] && !ovf_vec[0];
    assign irq     = ovf_vec[0];

endmodule

// File: rtl/memperf_checker.sv
// Property checks for memperf_counter_bank, bound into every instance.
// Observes the write selects, run gate, control words and counts.
module memperf_checker #(
    parameter int NUM_CTR     = 4,
    parameter int CNT_W       = 32,
    parameter bit LEGACY_WRAP = 1'b0
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     irq,
    input logic                     run_all,
    input logic [NUM_CTR-1:0]       wr_sel,
    input logic [NUM_CTR-1:0]       ovf_vec,
    input logic [NUM_CTR*32-1:0]    ctl_flat,
    input logic [NUM_CTR*CNT_W-1:0] cnt_flat
);

    logic [CNT_W-1:0] cnt0;
    logic             unused_ctl;

    assign cnt0       = cnt_flat[0 +: CNT_W];
    assign unused_ctl = ^ctl_flat;

    // R3: cycle counter steps by one on each running clock
    p_cycle_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (run_all && !wr_sel[0] && !(&cnt0)) |=> (cnt0 == $past(cnt0) + CNT_W'(1)));

    // R5: with the bank halted and no writes, no count moves
    p_halt_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!run_all && (wr_sel == '0)) |=> $stable(cnt_flat));

    // R6: interrupt stays high until counter 0 is written
    p_irq_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !wr_sel[0]) |=> irq);

    // R6: interrupt implies the bank is frozen
    p_irq_frozen_r6: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> !run_all);

    for (genvar k = 1; k < NUM_CTR; k++) begin : g_evt
        // R10: event clear bit comes back to 1 by itself
        p_clr_return_r10: assert property (@(posedge clk) disable iff (!rst_n)
            (!ctl_flat[k*32+1] && !wr_sel[k]) |=> ctl_flat[k*32+1]);

        // R7: event overflow never raises the interrupt
        p_evt_no_irq_r7: assert property (@(posedge clk) disable iff (!rst_n)
            ($rose(ovf_vec[k]) && !ovf_vec[0]) |-> !irq);

        if (!LEGACY_WRAP) begin : g_hold
            // R7: overflowed event counter holds its value
            p_evt_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
                (ovf_vec[k] && !wr_sel[k]) |=> $stable(cnt_flat[k*CNT_W +: CNT_W]));
        end else begin : g_wrap
            // R8: overflow flag is sticky while the counter keeps running
            p_evt_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
                (ovf_vec[k] && !wr_sel[k]) |=> ovf_vec[k]);
        end
    end

endmodule

bind memperf_counter_bank memperf_checker #(
    .NUM_CTR    (NUM_CTR),
    .CNT_W      (CNT_W),
    .LEGACY_WRAP(LEGACY_WRAP)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .irq     (irq),
    .run_all (run_all),
    .wr_sel  (wr_sel),
    .ovf_vec (ovf_vec),
    .ctl_flat(ctl_flat),
    .cnt_flat(cnt_flat)
);

// File: tb/tb_memperf_counter_bank.sv
`timescale 1ns/1ps
// Bench: two instances (hold and wrap overflow) with narrow counters, a
// behavioural model stepped at each rising edge, compared every clock.
module tb_memperf_counter_bank;

    localparam int CW   = 12;
    localparam int PL   = 4;
    localparam int MAXV = (1 << CW) - 1;

    logic        clk   = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr    = 1'b0;
    logic [7:0]  addr  = 8'h00;
    logic [31:0] wdata = 32'h0;
    logic [63:0] stb   = '0;
    logic [31:0] rd0, rd1;
    logic        irq0, irq1;

    int    checks   = 0;
    int    failures = 0;
    int    stb_mode = 0;
    int    rot      = 0;
    string cur_req  = "R1";

    int unsigned m_cnt [2][4];
    bit          m_en  [2][4];
    bit          m_clr [2][4];
    bit          m_ovf [2][4];
    bit [7:0]    m_pre [2][4];
    bit [7:0]    m_sel [2][4];
    bit          m_leg [2] = '{1'b0, 1'b1};

    always #2.5 clk = ~clk;

    memperf_counter_bank #(.CNT_W(CW), .PRE_LSB(PL), .LEGACY_WRAP(1'b0)) dut (
        .clk(clk), .rst_n(rst_n), .reg_wr(wr), .reg_addr(addr), .reg_wdata(wdata),
        .reg_rdata(rd0), .evt_strobe(stb), .irq(irq0));

    memperf_counter_bank #(.CNT_W(CW), .PRE_LSB(PL), .LEGACY_WRAP(1'b1)) dut_leg (
        .clk(clk), .rst_n(rst_n), .reg_wr(wr), .reg_addr(addr), .reg_wdata(wdata),
        .reg_rdata(rd1), .evt_strobe(stb), .irq(irq1));

    function automatic void model_reset();
        for (int i = 0; i < 2; i++) begin
            for (int k = 0; k < 4; k++) begin
                m_cnt[i][k] = 0; m_en[i][k] = 0; m_ovf[i][k] = 0;
                m_clr[i][k] = (k != 0); m_pre[i][k] = 0; m_sel[i][k] = 0;
            end
        end
    endfunction

    // One rising edge of the behaviour described by R3..R12
    function automatic void model_edge(int i, bit w, logic [7:0] a, logic [31:0] d, logic [63:0] s);
        bit run;
        int wn;
        run = m_en[i][0] && !m_ovf[i][0];
        wn  = -1;
        if (w && a[1:0] == 2'b00 && a < 8'h10) wn = int'(a[7:2]);
        for (int k = 0; k < 4; k++) begin
            bit ws, hit, inc, cf, pf, nov;
            int unsigned nc;
            ws  = (wn == k);
            hit = 0;
            if (m_sel[i][k] < 64) hit = s[m_sel[i][k]];
            if (k == 0) inc = run;
            else        inc = run && m_en[i][k] && hit && (m_leg[i] || !m_ovf[i][k]);
            if (k == 0) cf = ws && !m_clr[i][0] && d[1];
            else        cf = ws && !d[1];
            pf  = (k == 0) && ws && !m_en[i][0] && d[2] && (d[23:16] != 0);
            nc  = m_cnt[i][k];
            nov = m_ovf[i][k];
            if (cf || pf) begin
                if (cf) begin nc = 0; nov = 0; end
                if (pf) nc = (nc & ~(32'hFF << PL)) | (32'(d[23:16]) << PL);
            end else if (inc) begin
                if (nc == MAXV) begin
                    nov = 1;
                    nc  = (k == 0 || m_leg[i]) ? 0 : MAXV;
                end else begin
                    nc = nc + 1;
                end
            end
            m_cnt[i][k] = nc;
            m_ovf[i][k] = nov;
            if (ws) begin
                m_en[i][k]  = d[2];
                m_clr[i][k] = d[1];
                m_pre[i][k] = d[23:16];
                if (k != 0) m_sel[i][k] = d[31:24];
            end else if (k != 0) begin
                m_clr[i][k] = 1;
            end
        end
    endfunction

    function automatic logic [31:0] exp_rd(int i, logic [7:0] a);
        logic [31:0] r;
        int k;
        r = '0;
        if (a[1:0] == 2'b00) begin
            if (a < 8'h10) begin
                k = int'(a[7:2]);
                r = {m_sel[i][k], m_pre[i][k], 13'b0, m_en[i][k], m_clr[i][k], m_ovf[i][k]};
            end else if (a >= 8'h20 && a < 8'h30) begin
                k = int'(a[7:2]) - 8;
                r = m_cnt[i][k];
            end
        end
        return r;
    endfunction

    task automatic check32(string tag, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    task automatic compare();
        check32(cur_req, $sformatf("inst0 rdata@%h", addr), rd0, exp_rd(0, addr));
        check32(cur_req, $sformatf("inst1 rdata@%h", addr), rd1, exp_rd(1, addr));
        check32(cur_req, "inst0 irq", {31'b0, irq0}, {31'b0, m_ovf[0][0]});
        check32(cur_req, "inst1 irq", {31'b0, irq1}, {31'b0, m_ovf[1][0]});
    endtask

    function automatic logic [63:0] gen_stb();
        case (stb_mode)
            1:       return {$urandom, $urandom};
            2:       return {$urandom, $urandom} | 64'h10;
            3:       return '1;
            default: return '0;
        endcase
    endfunction

    // Drive one clock: inputs after a falling edge, model at the rise, compare at the fall
    task automatic step(bit w, logic [7:0] a, logic [31:0] d);
        wr    = w;
        addr  = a;
        wdata = d;
        stb   = gen_stb();
        @(posedge clk);
        model_edge(0, w, a, d, stb);
        model_edge(1, w, a, d, stb);
        @(negedge clk);
        compare();
    endtask

    task automatic idle(int n);
        for (int j = 0; j < n; j++) begin
            int x;
            x = rot % 8;
            step(1'b0, (x < 4) ? 8'(x * 4) : 8'(8'h20 + (x - 4) * 4), 32'h0);
            rot++;
        end
    endtask

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        failures++;
        $display("FAIL watchdog expired in %s", cur_req);
        finish_run();
    end

    initial begin
        model_reset();
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        cur_req = "R1";
        compare();
        idle(8);

        cur_req = "R3";             // evsel write ignored on counter 0
        step(1'b1, 8'h00, 32'hAB00_0006);
        idle(16);

        cur_req = "R2";             // fields, read-only ovf bit, count offsets
        stb_mode = 1;
        step(1'b1, 8'h04, 32'h0412_0005);
        step(1'b1, 8'h08, 32'h0500_0004);
        step(1'b1, 8'h0C, 32'h3700_0004);
        idle(24);

        cur_req = "R4";             // code beyond strobe range never counts
        idle(40);
        stb_mode = 3;
        step(1'b1, 8'h0C, 32'h8000_0006);
        idle(16);
        step(1'b1, 8'h0C, 32'h3700_0006);
        stb_mode = 1;
        idle(16);

        cur_req = "R10";            // event clear and self-restoring clear bit
        step(1'b1, 8'h08, 32'h0500_0004);
        step(1'b0, 8'h08, 32'h0);
        step(1'b1, 8'h08, 32'h0500_0006);
        idle(8);

        cur_req = "R5";             // cycle counter disable freezes all
        stb_mode = 3;
        step(1'b1, 8'h00, 32'h0000_0002);
        idle(20);
        step(1'b1, 8'h00, 32'h0000_0006);
        idle(10);

        cur_req = "R9";             // 0 then 1 handshake on counter 0
        step(1'b1, 8'h00, 32'h0000_0006);
        idle(5);
        step(1'b1, 8'h00, 32'h0000_0004);
        idle(3);
        step(1'b1, 8'h00, 32'h0000_0006);
        idle(5);

        cur_req = "R7";             // event overflow: hold (inst0) or wrap (inst1)
        stb_mode = 2;
        step(1'b1, 8'h04, 32'h0400_0004);
        step(1'b1, 8'h00, 32'h0000_0004);
        step(1'b1, 8'h00, 32'h0000_0006);
        idle(2500);
        step(1'b1, 8'h00, 32'h0000_0004);
        step(1'b1, 8'h00, 32'h0000_0006);
        idle(2000);
        step(1'b0, 8'h24, 32'h0);
        check32("R7", "inst0 count1 held", rd0, 32'(MAXV));
        step(1'b0, 8'h04, 32'h0);
        check32("R7", "inst0 ovf1", {31'b0, rd0[0]}, 32'h1);
        check32("R7", "inst0 irq", {31'b0, irq0}, 32'h0);
        cur_req = "R8";
        check32("R8", "inst1 ovf1", {31'b0, rd1[0]}, 32'h1);
        step(1'b0, 8'h24, 32'h0);
        check32("R8", "inst1 count1 wrapped", {31'b0, rd1 < 32'd1000}, 32'h1);
        idle(16);

        cur_req = "R11";            // preload makes counter 0 wrap early
        stb_mode = 3;
        step(1'b1, 8'h00, 32'h0000_0000);
        step(1'b1, 8'h00, 32'h00FF_0006);
        step(1'b0, 8'h20, 32'h0);
        check32("R11", "inst0 preloaded count0", rd0, 32'h0000_0FF1);
        idle(40);

        cur_req = "R6";             // frozen bank and held interrupt
        check32("R6", "inst0 irq after wrap", {31'b0, irq0}, 32'h1);
        idle(10);
        step(1'b1, 8'h00, 32'h0000_0000);
        check32("R6", "inst0 irq before clear", {31'b0, irq0}, 32'h1);
        step(1'b1, 8'h00, 32'h0000_0006);
        check32("R6", "inst0 irq after clear", {31'b0, irq0}, 32'h0);
        idle(10);

        cur_req = "R12";            // unmapped and read-only offsets
        step(1'b1, 8'h24, 32'hFFFF_FFFF);
        step(1'b1, 8'h40, 32'hFFFF_FFFF);
        step(1'b1, 8'h01, 32'h0000_0000);
        step(1'b1, 8'h0D, 32'h0000_0000);
        step(1'b0, 8'h40, 32'h0);
        step(1'b0, 8'h13, 32'h0);
        step(1'b0, 8'h02, 32'h0);
        step(1'b0, 8'h30, 32'h0);
        step(1'b0, 8'hFC, 32'h0);
        step(1'b0, 8'h21, 32'h0);
        idle(8);

        finish_run();
    end

endmodule